// File: doc/BRIEF.md
# Serial LCD Byte Writer

This block sends one byte at a time to a graphic display controller over a four-wire serial link. The four wires are an active-low chip select, a data/command select, a serial clock and a serial data line. A host puts a byte and a data-or-command flag on the inputs and pulses a start strobe. The block then frames that byte with its own chip select and drives the data/command line for the whole frame. It shifts the eight bits out most significant bit first and reports completion with a one-cycle done strobe.

The serial clock is made in logic. Every setup, low, high and release phase lasts `PHASE_CYCLES` system clocks. In each bit the clock goes low, the data line takes the new bit, and the clock then rises so the display samples the bit on the rising edge. Two board variants route the four wires to the 4-bit output port in different orders. A static selection input picks the routing.

Top module: `lcd_serial_writer`

## Requirements
- R1: After reset, chip select and the serial clock are high, while the data line, data/command, `busy_o` and `done_o` are low.
- R2: Chip select goes low `PHASE_CYCLES` cycles before the first falling edge of the serial clock. It goes back high `PHASE_CYCLES` cycles after the eighth rising edge.
- R3: Each frame has exactly eight rising edges of the serial clock. The bits seen on those edges, in order, form the byte, most significant bit first.
- R4: The data line changes only while the serial clock is low.
- R5: The data/command line is 1 for a data byte (`is_data_i`=1) and 0 for a command byte, and it holds steady while chip select is low.
- R6: Each low phase and each high phase of the serial clock inside a frame lasts exactly `PHASE_CYCLES` system clocks.
- R7: With `wiring_sel_i`=0, port bit 0 is data/command, bit 1 is chip select, bit 2 is the serial clock and bit 3 is serial data.
- R8: With `wiring_sel_i`=1, port bit 0 is serial data, bit 1 is the serial clock, bit 2 is data/command and bit 3 is chip select.
- R9: `busy_o` is high from the cycle after an accepted start until the frame ends. A start pulse while busy has no effect: no byte is captured and no extra frame follows.
- R10: `done_o` is high for exactly one cycle per frame. That cycle is the first one with chip select high again and `busy_o` low.
- R11: Between frames, chip select and the serial clock rest high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken when not busy |
| byte_i | input | BYTE_BITS | Byte to send |
| is_data_i | input | 1 | 1 = data byte, 0 = command byte |
| wiring_sel_i | input | 1 | Board routing of the four wires onto the port |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| lcd_port_o | output | 4 | Chip select, data/command, clock and data, routed per `wiring_sel_i` |

## Verification
The bench builds the block with `PHASE_CYCLES`=3 and `BYTE_BITS`=8. A divider above one separates setup, low, high and release phases by several cycles, so an off-by-one in the phase timer shows up as a wrong phase length. It also keeps each frame to 54 cycles, which leaves room for several bit patterns, both wirings and a start strobe arriving in mid-frame. The bench decodes the port through the selected routing and rebuilds each byte from the rising clock edges, so a swapped pin or a reversed bit order shows up as a wrong byte.

// File: rtl/lcd_wr_pkg.sv
// Shared types for the serial LCD byte writer.
// Assumes two board routings only; the select input is static between frames.
package lcd_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_RELEASE
    } wr_state_e;

    // Place the four link wires on the port bits for the chosen board routing.
    function automatic logic [3:0] route_pins(input logic sel, input logic cs_n,
                                              input logic dc, input logic sck,
                                              input logic sda);
        if (sel) route_pins = {cs_n, dc, sck, sda};
        else     route_pins = {sda, sck, cs_n, dc};
    endfunction

endpackage

// File: rtl/lcd_wr_phase_timer.sv
// Phase timer: counts system clocks within one link phase.
// tick_o is high in the last cycle of a phase; restart_i zeroes the count.
// Assumes PHASE_CYCLES >= 1.
module lcd_wr_phase_timer #(
    parameter int PHASE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/lcd_wr_shifter.sv
// Byte shifter: holds the byte, presents its current MSB, and counts shifts.
// all_sent_o is high once BYTE_BITS bits have been shifted past the MSB.
module lcd_wr_shifter #(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [BYTE_BITS-1:0] byte_i,
    input  logic                 shift_i,
    output logic                 msb_o,
    output logic                 all_sent_o
);
    localparam int NW = $clog2(BYTE_BITS + 1);
    localparam logic [NW-1:0] FULL = NW'(BYTE_BITS);

    logic [BYTE_BITS-1:0] sr_q;
    logic [NW-1:0]        sent_q;

    // Load a new byte or move the next bit into the MSB position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            sent_q <= '0;
        end else if (load_i) begin
            sr_q   <= byte_i;
            sent_q <= '0;
        end else if (shift_i) begin
            sr_q   <= {sr_q[BYTE_BITS-2:0], 1'b0};
            sent_q <= sent_q + 1'b1;
        end
    end

    assign msb_o      = sr_q[BYTE_BITS-1];
    assign all_sent_o = (sent_q == FULL);

endmodule

// File: rtl/lcd_wr_pinmap.sv
// Pin router: places chip select, data/command, clock and data on the
// 4-bit port in the order of the selected board routing. Purely combinational.
module lcd_wr_pinmap
    import lcd_wr_pkg::*;
(
    input  logic       sel_i,
    input  logic       cs_n_i,
    input  logic       dc_i,
    input  logic       sck_i,
    input  logic       sda_i,
    output logic [3:0] port_o
);
    // Route the registered link wires to the port.
    always_comb port_o = route_pins(sel_i, cs_n_i, dc_i, sck_i, sda_i);

endmodule

// File: rtl/lcd_serial_writer.sv
// Serial LCD byte writer top. Sequences setup, eight low/high bit phases and
// release, each lasting PHASE_CYCLES clocks, and drives registered link wires.
// Assumes wiring_sel_i is static while a frame is in progress.
module lcd_serial_writer
    import lcd_wr_pkg::*;
#(
    parameter int PHASE_CYCLES = 4,
    parameter int BYTE_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [BYTE_BITS-1:0] byte_i,
    input  logic                 is_data_i,
    input  logic                 wiring_sel_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [3:0]           lcd_port_o
);
    wr_state_e state_q;
    logic cs_n_q, sck_q, sda_q, dc_q, done_q;
    logic tick, restart, load, shift, msb, all_sent;

    assign load    = (state_q == ST_IDLE) && start_i;
    assign restart = (state_q == ST_IDLE) || tick;
    assign shift   = (state_q == ST_LOW) && tick;

    lcd_wr_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .tick_o(tick)
    );

    lcd_wr_shifter #(.BYTE_BITS(BYTE_BITS)) i_shifter (
        .clk(clk), .rst_n(rst_n), .load_i(load), .byte_i(byte_i),
        .shift_i(shift), .msb_o(msb), .all_sent_o(all_sent)
    );

    // Frame sequencer and registered link wires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
            sck_q   <= 1'b1;
            sda_q   <= 1'b0;
            dc_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_SETUP;
                        cs_n_q  <= 1'b0;
                        dc_q    <= is_data_i;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        state_q <= ST_LOW;
                        sck_q   <= 1'b0;
                        sda_q   <= msb;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        state_q <= ST_HIGH;
                        sck_q   <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (all_sent) begin
                            state_q <= ST_RELEASE;
                            cs_n_q  <= 1'b1;
                        end else begin
                            state_q <= ST_LOW;
                            sck_q   <= 1'b0;
                            sda_q   <= msb;
                        end
                    end
                end
                ST_RELEASE: begin
                    if (tick) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;

    lcd_wr_pinmap i_pinmap (
        .sel_i(wiring_sel_i), .cs_n_i(cs_n_q), .dc_i(dc_q),
        .sck_i(sck_q), .sda_i(sda_q), .port_o(lcd_port_o)
    );

endmodule

// File: rtl/lcd_serial_writer_chk.sv
// Property checker for the serial LCD byte writer, bound to the top.
// Observes the registered link wires and the handshake outputs.
module lcd_serial_writer_chk #(
    parameter int PHASE_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic cs_n_q,
    input logic sck_q,
    input logic sda_q,
    input logic dc_q
);
    logic [15:0] low_run_q;

    // Length of the current low run of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n || sck_q) low_run_q <= '0;
        else                 low_run_q <= low_run_q + 1'b1;
    end

    // R4: data only moves while the clock is low
    a_r4_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(sda_q));

    // R2: clock low only inside a chip-select frame
    a_r2_clock_low_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_q |-> !cs_n_q);

    // R5: data/command steady within a frame
    a_r5_dc_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_q && $past(!cs_n_q)) |-> $stable(dc_q));

    // R6: low phase length
    a_r6_low_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && !$past(sck_q)) |-> (low_run_q == 16'(PHASE_CYCLES)));

    // R10: done is a single pulse, seen with chip select released and idle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_q && !busy_o));

    // R11: idle rest levels
    a_r11_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_q && sck_q));

    // R9: a start while busy does not end or restart the frame at once
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !cs_n_q) |=> busy_o);

endmodule

bind lcd_serial_writer lcd_serial_writer_chk #(.PHASE_CYCLES(PHASE_CYCLES)) i_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .cs_n_q(cs_n_q), .sck_q(sck_q), .sda_q(sda_q), .dc_q(dc_q)
);

// File: tb/test_lcd_serial_writer.sv
// Directed bench for the serial LCD byte writer: a port monitor decodes the
// link through the selected routing and checks phase lengths and bytes.
module test_lcd_serial_writer;
    localparam int P  = 3;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [NB-1:0] byte_i = '0;
    logic          is_data_i = 1'b0;
    logic          wiring_sel_i = 1'b0;
    logic          busy_o, done_o;
    logic [3:0]    lcd_port_o;

    int checks = 0;
    int errors = 0;

    lcd_serial_writer #(.PHASE_CYCLES(P), .BYTE_BITS(NB)) i_lcd_serial_writer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_i(byte_i),
        .is_data_i(is_data_i), .wiring_sel_i(wiring_sel_i), .busy_o(busy_o),
        .done_o(done_o), .lcd_port_o(lcd_port_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor state
    int  cyc = 0, last_evt = 0, frames = 0, rises = 0, dones = 0;
    bit  p_cs = 1, p_sck = 1, p_done = 0, exp_dc = 0;
    logic [NB-1:0] cap = '0;
    logic m_cs, m_sck, m_sda, m_dc;

    always_comb begin
        if (wiring_sel_i) {m_cs, m_dc, m_sck, m_sda} = lcd_port_o;
        else              {m_sda, m_sck, m_cs, m_dc} = lcd_port_o;
    end

    // Decode the link on falling clock edges and check its timing.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_cs && !m_cs) begin
                frames++; rises = 0; last_evt = cyc;
            end else if (!p_cs && m_cs) begin
                chk(cyc - last_evt == P, "R2 release delay", cyc - last_evt, P);
                chk(rises == NB, "R3 rising edges per frame", rises, NB);
                last_evt = cyc;
            end else if (!m_cs && p_sck && !m_sck) begin
                chk(cyc - last_evt == P, "R6/R2 phase before clock fall", cyc - last_evt, P);
                last_evt = cyc;
            end else if (!m_cs && !p_sck && m_sck) begin
                chk(cyc - last_evt == P, "R6 low phase", cyc - last_evt, P);
                chk(m_dc == exp_dc, "R5 dc level", m_dc, exp_dc);
                cap = {cap[NB-2:0], m_sda};
                rises++;
                last_evt = cyc;
            end
            if (done_o) begin
                dones++;
                chk(!p_done, "R10 done width", 2, 1);
                chk(m_cs == 1'b1 && !busy_o, "R10 done with cs high", {m_cs, busy_o}, 2);
            end
            p_cs = m_cs; p_sck = m_sck; p_done = done_o;
        end
    end

    task automatic pulse_start(input logic [NB-1:0] b, input bit d);
        @(negedge clk);
        byte_i = b; is_data_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 * P && busy_o; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // One byte: checks the captured value, framing, done count and rest levels.
    task automatic t_byte(input logic [NB-1:0] b, input bit d);
        int f0 = frames, d0 = dones;
        exp_dc = d;
        pulse_start(b, d);
        chk(busy_o, "R9 busy after start", busy_o, 1);
        wait_idle();
        chk(cap == b, "R3 byte MSB first", cap, b);
        chk(frames == f0 + 1, "R2 one frame", frames - f0, 1);
        chk(dones == d0 + 1, "R10 one done", dones - d0, 1);
        chk(m_cs && m_sck && !busy_o, "R11 rest levels", {m_cs, m_sck, busy_o}, 6);
    endtask

    task automatic t_reset();
        chk(lcd_port_o == 4'b0110, "R1 R7 reset port", lcd_port_o, 4'b0110);
        chk(!busy_o && !done_o, "R1 busy/done low", {busy_o, done_o}, 0);
    endtask

    task automatic t_busy_ignore();
        int f0 = frames;
        exp_dc = 1'b1;
        pulse_start(8'hC3, 1'b1);
        repeat (5 * P) @(negedge clk);
        byte_i = 8'h18; is_data_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        chk(cap == 8'hC3, "R9 byte kept during busy start", cap, 8'hC3);
        repeat (25 * P) @(negedge clk);
        chk(frames == f0 + 1, "R9 no extra frame", frames - f0, 1);
        chk(!busy_o, "R9 idle after ignored start", busy_o, 0);
    endtask

    task automatic t_idle_port(input bit sel, input logic [3:0] exp, input string tag);
        wiring_sel_i = sel;
        @(negedge clk);
        chk(lcd_port_o == exp, tag, lcd_port_o, exp);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_byte(8'hA5, 1'b1);
        t_byte(8'h3C, 1'b0);
        t_byte(8'h80, 1'b1);
        t_byte(8'h01, 1'b0);
        t_byte(8'hFF, 1'b1);
        t_byte(8'h00, 1'b0);
        t_idle_port(1'b0, 4'b0110, "R7 idle port wiring 0");
        t_idle_port(1'b1, 4'b1010, "R8 idle port wiring 1");
        t_byte(8'h5A, 1'b1);
        t_byte(8'h96, 1'b0);
        t_byte(8'h00, 1'b0);
        t_idle_port(1'b1, 4'b1010, "R8 idle after command");
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule